// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of one of two digital input signals. It counts rising edges of the chosen signal over a gate window. The window is a whole number of periods of an external 1 ms timebase tick. A measurement starts with a one-cycle START strobe, which comes from a register write. The strobe clears the count and the overflow flag, raises BUSY, and captures the gate code and the source select. The gate then opens on the next timebase tick.

The gate stays open for 1, 4, 16 or 64 tick periods. On the tick that ends the window, the gate closes and BUSY falls on that same clock edge. From then on the count is frozen until the next START. Software polls BUSY. It reads the result only when BUSY=0 and OVER=0. OVER means that more edges arrived than the counter can hold. In that case the count stays at its all-ones value.

Top module: `fc_freq_counter`

## Requirements
- R1: After reset, `busy`=0, `over`=0 and `result`=0.
- R2: In the clock cycle that follows a cycle with `start`=1, `busy`=1, `result`=0 and `over`=0.
- R3: Edges that arrive after START but before the next `tick_1ms` pulse are not counted. The gate opens on the first tick after START.
- R4: The gate code is captured at START. The window then lasts this many tick periods: code 00 gives 1, code 01 gives 4, code 10 gives 16 and code 11 gives 64. `busy` stays 1 through every earlier tick of the window.
- R5: `busy` falls on the clock edge that samples the tick ending the window. After that, further edges do not change `result`.
- R6: The source select is captured at START. If bit 0 is 1, `sig_in1` is counted, and bit 0 takes priority. If only bit 1 is 1, `sig_in2` is counted. If both bits are 0, nothing is counted.
- R7: Each rising edge of the selected input adds one to `result`, which is a plain binary count. This holds as long as each high and low level lasts at least one clock cycle.
- R8: An edge that arrives while the count is all ones sets `over`. The count then stays at all ones. `over` stays set until the next START.
- R9: A START that arrives during a measurement abandons it. It clears the count and arms a new measurement.
- R10: Without a START, ticks and input edges have no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle timebase pulse, once per millisecond |
| gate_code | input | 2 | Gate window code, captured at START |
| src_sel | input | 2 | Source select: bit 0 picks sig_in1, bit 1 picks sig_in2 |
| start | input | 1 | One-cycle strobe that starts a measurement |
| sig_in1 | input | 1 | First asynchronous signal to measure |
| sig_in2 | input | 1 | Second asynchronous signal to measure |
| result | output | CNT_W | Edge count, binary |
| busy | output | 1 | Measurement armed or gate open |
| over | output | 1 | Count overflow, sticky until START |

## Verification
The bench sweeps every combination of gate code and source select. It drives two edges on the second input for every edge on the first, so a wrong mux or a wrong priority gives a count that is off by a factor of two or is zero instead of N.

Edges are also placed just before the gate opens and after it closes. An early-open or late-close design picks up those extra edges.

The bench checks BUSY before every tick of the window, which exposes a window that is off by a power of four or off by one tick. Counts of 255, 256 and 300 on an 8-bit counter cover the overflow boundary. A wrapping counter, or an OVER flag that is off by one, reports the wrong flag or wrong value.

A restart in mid-window catches a count that is not cleared. Idle ticks catch a gate that opens without START.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Each code step multiplies the window by 2**GATE_STEP_LOG2 ticks
    localparam int GATE_STEP_LOG2 = 2;
    localparam int GATE_CODE_W    = 2;
    localparam int MAX_WIN_LOG2   = ((1 << GATE_CODE_W) - 1) * GATE_STEP_LOG2;
    localparam int TICK_CNT_W     = MAX_WIN_LOG2 + 1;
    localparam int NUM_SRC        = 2;

    typedef enum logic [1:0] {
        GC_IDLE  = 2'd0,
        GC_ARMED = 2'd1,
        GC_OPEN  = 2'd2
    } gc_state_e;

    // Control handed from the gate sequencer to the counter
    typedef struct packed {
        logic clear;
        logic open;
    } gate_ctl_t;

    // Index of the last tick in a window of the given code
    function automatic logic [TICK_CNT_W-1:0] win_last(input logic [GATE_CODE_W-1:0] code);
        logic [TICK_CNT_W-1:0] one;
        one = 1;
        return (one << (int'(code) * GATE_STEP_LOG2)) - one;
    endfunction

    // Source priority: bit 0 first, then bit 1, otherwise none
    function automatic logic pick_edge(input logic [NUM_SRC-1:0] sel,
                                       input logic [NUM_SRC-1:0] rise);
        logic hit;
        hit = 1'b0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (sel[k]) hit = rise[k];
        end
        return hit;
    endfunction

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
    parameter int NUM_IN   = 2,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] raw,
    output logic [NUM_IN-1:0] rise
);
    localparam int PIPE_LEN = SYNC_LEN + 1;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_src
        logic [PIPE_LEN-1:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[PIPE_LEN-2:0], raw[i]};
        end

        assign rise[i] = pipe[PIPE_LEN-2] & ~pipe[PIPE_LEN-1];

        // R7
        rise_single_chk: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end

endmodule

// File: rtl/fc_gate_ctrl.sv
module fc_gate_ctrl
    import fc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   tick,
    input  logic [GATE_CODE_W-1:0] code,
    output gate_ctl_t              ctl,
    output logic                   busy
);
    gc_state_e               state;
    logic [GATE_CODE_W-1:0]  code_q;
    logic [TICK_CNT_W-1:0]   tick_cnt;
    logic                    last_tick;

    assign last_tick = (tick_cnt == win_last(code_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= GC_IDLE;
            code_q   <= '0;
            tick_cnt <= '0;
        end else if (start) begin
            state    <= GC_ARMED;
            code_q   <= code;
            tick_cnt <= '0;
        end else if (tick) begin
            unique case (state)
                GC_ARMED: begin
                    state    <= GC_OPEN;
                    tick_cnt <= '0;
                end
                GC_OPEN: begin
                    if (last_tick) state <= GC_IDLE;
                    else           tick_cnt <= tick_cnt + 1'b1;
                end
                default: state <= GC_IDLE;
            endcase
        end
    end

    assign busy      = (state != GC_IDLE);
    assign ctl.open  = (state == GC_OPEN);
    assign ctl.clear = start;

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == GC_IDLE && !start) |=> (state == GC_IDLE));

    // R3
    open_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.open) |-> ($past(tick) && !$past(start)));

    // R5
    close_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(tick) && $past(ctl.open)));

    // R4
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.open |-> (tick_cnt <= win_last(code_q)));

endmodule

// File: rtl/fc_count.sv
module fc_count
    import fc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  gate_ctl_t        ctl,
    input  logic             edge_hit,
    output logic [CNT_W-1:0] cnt,
    output logic             over
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            cnt  <= '0;
            over <= 1'b0;
        end else if (ctl.open && edge_hit) begin
            if (cnt == CNT_MAX) over <= 1'b1;
            else                cnt  <= cnt + 1'b1;
        end
    end

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.clear |=> (cnt == '0 && !over));

    // R8
    over_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (over && !ctl.clear) |=> over);

    // R8
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        over |-> (cnt == CNT_MAX));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl.open && !ctl.clear) |=> $stable(cnt));

endmodule

// File: rtl/fc_freq_counter.sv
module fc_freq_counter
    import fc_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int SYNC_LEN = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_1ms,
    input  logic [GATE_CODE_W-1:0] gate_code,
    input  logic [NUM_SRC-1:0]     src_sel,
    input  logic                   start,
    input  logic                   sig_in1,
    input  logic                   sig_in2,
    output logic [CNT_W-1:0]       result,
    output logic                   busy,
    output logic                   over
);
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] sel_q;
    logic               edge_hit;
    gate_ctl_t          ctl;

    always_ff @(posedge clk) begin
        if (rst)        sel_q <= '0;
        else if (start) sel_q <= src_sel;
    end

    fc_edge_sync #(
        .NUM_IN   (NUM_SRC),
        .SYNC_LEN (SYNC_LEN)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .raw  ({sig_in2, sig_in1}),
        .rise (rise)
    );

    assign edge_hit = pick_edge(sel_q, rise);

    fc_gate_ctrl gate_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick_1ms),
        .code  (gate_code),
        .ctl   (ctl),
        .busy  (busy)
    );

    fc_count #(
        .CNT_W (CNT_W)
    ) count_i (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .edge_hit (edge_hit),
        .cnt      (result),
        .over     (over)
    );

    // R6
    no_source_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == '0 && !start) |=> $stable(result));

endmodule

// File: tb/fc_freq_counter_tb_top.sv
module fc_freq_counter_tb_top;

    localparam int W     = 8;
    localparam int MAXV  = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_1ms = 1'b0;
    logic [1:0]   gate_code = '0;
    logic [1:0]   src_sel = '0;
    logic         start = 1'b0;
    logic         sig_in1 = 1'b0;
    logic         sig_in2 = 1'b0;
    logic [W-1:0] result;
    logic         busy;
    logic         over;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fc_freq_counter #(.CNT_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_1ms  (tick_1ms),
        .gate_code (gate_code),
        .src_sel   (src_sel),
        .start     (start),
        .sig_in1   (sig_in1),
        .sig_in2   (sig_in2),
        .result    (result),
        .busy      (busy),
        .over      (over)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk) begin
            sig_in1 = 1'b0;
            sig_in2 = 1'b0;
        end
    endtask

    // One rising edge on sig_in1 and two on sig_in2, four cycles
    task automatic slot();
        @(negedge clk) begin sig_in1 = 1'b1; sig_in2 = 1'b1; end
        @(negedge clk) begin sig_in1 = 1'b1; sig_in2 = 1'b0; end
        @(negedge clk) begin sig_in1 = 1'b0; sig_in2 = 1'b1; end
        @(negedge clk) begin sig_in1 = 1'b0; sig_in2 = 1'b0; end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
    endtask

    task automatic do_start(input int code, input int sel);
        @(negedge clk) begin
            gate_code = code[1:0];
            src_sel   = sel[1:0];
            start     = 1'b1;
        end
        @(negedge clk) start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        check("R2 result cleared", int'(result), 0);
        check("R8 over cleared by start", int'(over), 0);
    endtask

    task automatic measure(input int code, input int sel, input int n);
        int w;
        int rem;
        int e;
        w   = 1 << (2 * code);
        rem = n;
        do_start(code, sel);
        repeat (3) slot();
        idle(6);
        check($sformatf("R3 no count before gate code=%0d sel=%0d", code, sel), int'(result), 0);
        pulse_tick();
        for (int t = 0; t < w; t++) begin
            int q;
            q = (rem > 8) ? 8 : rem;
            idle(2);
            repeat (q) slot();
            rem -= q;
            idle(6 + (8 - q) * 4);
            check($sformatf("R4 busy inside window code=%0d tick=%0d", code, t), int'(busy), 1);
            pulse_tick();
        end
        check($sformatf("R5 busy drops on closing tick code=%0d", code), int'(busy), 0);
        repeat (3) slot();
        idle(6);
        e = sel[0] ? n : (sel[1] ? 2 * n : 0);
        check($sformatf("R6 R7 count code=%0d sel=%0d n=%0d", code, sel, n),
              int'(result), (e > MAXV) ? MAXV : e);
        check($sformatf("R8 over flag code=%0d sel=%0d n=%0d", code, sel, n),
              int'(over), (e > MAXV) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check("R1 busy at reset", int'(busy), 0);
        check("R1 over at reset", int'(over), 0);
        check("R1 result at reset", int'(result), 0);

        // R10: ticks and edges while idle
        pulse_tick();
        repeat (4) slot();
        idle(6);
        pulse_tick();
        idle(4);
        check("R10 idle busy", int'(busy), 0);
        check("R10 idle result", int'(result), 0);

        // Sweep of gate codes and source selects
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 4; s++) begin
                measure(c, s, 3 + c * 4 + s);
            end
        end

        // R8 boundary around the 8-bit limit
        measure(3, 1, MAXV);
        measure(3, 1, MAXV + 1);
        measure(3, 1, 300);

        // R9 restart in mid-window
        do_start(2, 1);
        pulse_tick();
        repeat (5) slot();
        idle(6);
        check("R9 counting before restart", int'(result), 5);
        do_start(0, 1);
        check("R9 still busy after restart", int'(busy), 1);
        measure(1, 2, 7);

        // R10 idle after a measurement leaves the result alone
        pulse_tick();
        repeat (5) slot();
        idle(6);
        pulse_tick();
        idle(4);
        check("R10 result held while idle", int'(result), 14);
        check("R10 busy held low while idle", int'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule